// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Polarity Control

This block collects nine external level-sensitive interrupt inputs and steers them onto three active-high interrupt request outputs that feed a host interrupt controller. Every raw input first crosses a two-flop synchroniser. A polarity register then maps it to an internal active-high request. Three of the inputs have a polarity fixed in hardware. The other six take their polarity from software.

Each output line owns one 32-bit register. Its low field selects which sources may raise that line. Its upper field shows every source that has been seen active on that line, all at once, so software can scan from the highest-numbered source downward to find the cause. A pending bit stays set until software writes a one to it. Because every source is level sensitive, a pending bit sets again on the next clock after an acknowledge if its input is still active.

Software reaches the registers through a plain synchronous bus: a byte address, a write strobe, write data and combinational read data. The router does no edge detection, no vectoring and no priority encoding.

Top module: `irq_router`

## Requirements
- R1: After reset, every enable bit and every pending bit is 0 and all three outputs are low. The polarity register reads 0x0000_0102, because only the fixed bits show.
- R2: A change on a raw input reaches the pending field on the third rising clock edge after it is applied: two synchroniser edges and then the pending capture edge.
- R3: The polarity register is at byte offset 0x0. Bit n at 1 makes source n active high, and bit n at 0 makes it active low.
- R4: Sources 1 and 8 are always active high and source 2 is always active low. Writes to polarity bits 1, 2 and 8 are ignored, and a read returns 1, 0 and 1 for those bits.
- R5: The register for output line l is at byte offset 0x4 + 4*l. A write to it loads bits [8:0] as the enables of that line, where bit n enables source n.
- R6: Bits [24:16] of a line register are that line's pending flags, with bit 16+n for source n. A flag sets whenever source n's request is active, whatever the enable setting. It stays set after the request goes away, and any number of flags can be set at once.
- R7: Writing 1 to bit 16+n of a line register clears that flag on that line only. Writing 0 to a pending bit leaves it unchanged, and the other lines are not affected.
- R8: When a flag is acknowledged while its request is still active, the flag reads 0 in the cycle after the write and 1 again from the following cycle.
- R9: Output l is high exactly when line l has at least one source that is both pending and enabled. It follows the register state in the same cycle.
- R10: Bits [15:9] and [31:25] of a line register, and bits [31:9] of the polarity register, read as 0 and ignore writes. A read from any other offset, including an unaligned one, returns 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 9 | Raw interrupt inputs, asynchronous |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe, acts on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 3 | Interrupt request outputs, active high |

## Verification
Read data and the outputs follow the register state combinationally. A write therefore shows up in the first read sampled after the edge that performs it. An input change shows up only after the third edge, and a re-armed flag one edge after its acknowledge. The driver task queues each expected value in the same cycle that it sets the address. The monitor pops it at the next falling edge, so every comparison lands in the one cycle the requirement names. For the latency check, the flag is read in each cycle before the third edge, where it must still be clear, and then once after that edge.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

    // Kind of register selected by the current bus address
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_POL  = 2'd1,
        SEL_LINE = 2'd2
    } sel_e;

endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a vector of asynchronous level inputs
module irq_sync #(
    parameter int unsigned     WIDTH   = 1,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

    // R2: the first stage always holds the input from the previous edge
    a_r2_first_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (stage_q[0] == $past(d_i)));

endmodule

// File: rtl/irq_polarity.sv
`timescale 1ns/1ps
// Polarity register with hard-wired bits and request normalisation
module irq_polarity #(
    parameter int unsigned       NUM_SRC  = 9,
    parameter logic [NUM_SRC-1:0] FIX_MASK = '0,
    parameter logic [NUM_SRC-1:0] FIX_VAL  = '0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] level_i,
    output logic [NUM_SRC-1:0] pol_o,
    output logic [NUM_SRC-1:0] req_o
);

    localparam logic [NUM_SRC-1:0] CFG_MASK = ~FIX_MASK;
    localparam logic [NUM_SRC-1:0] FIX_BITS = FIX_VAL & FIX_MASK;

    logic [NUM_SRC-1:0] cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (wr_i) begin
            cfg_q <= wdata_i & CFG_MASK;
        end
    end

    // Fixed bits override whatever software stored
    assign pol_o = (cfg_q & CFG_MASK) | FIX_BITS;
    // Active high when polarity bit is 1, active low when 0
    assign req_o = ~(level_i ^ pol_o);

    // R3: configurable bits take the written value
    a_r3_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((pol_o & CFG_MASK) == ($past(wdata_i) & CFG_MASK)));

    // R4: fixed bits never move
    a_r4_fixed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pol_o & FIX_MASK) == $past(pol_o & FIX_MASK)));

    // R3: polarity changes only through a write
    a_r3_pol_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(pol_o));

endmodule

// File: rtl/irq_line.sv
`timescale 1ns/1ps
// One output line: enable field, sticky pending flags, request output
module irq_line #(
    parameter int unsigned NUM_SRC = 9
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] en_wdata_i,
    input  logic [NUM_SRC-1:0] ack_wdata_i,
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] ack;

    assign ack = wr_i ? ack_wdata_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= '0;
        end else if (wr_i) begin
            en_q <= en_wdata_i;
        end
    end

    // An acknowledge wins in its own cycle; a live request re-arms on the next edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | req_i) & ~ack;
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign irq_o  = |(en_q & pend_q);

    // R5: a write loads the enable field
    a_r5_en_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (en_q == $past(en_wdata_i)));

    // R5: enables hold without a write
    a_r5_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(en_q));

    // R7: acknowledged flags are clear after the write edge
    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((pend_q & $past(ack_wdata_i)) == '0));

    // R6: a flag drops only through an acknowledge
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R8: every active request is captured when no acknowledge is written
    a_r8_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> ((pend_q & $past(req_i)) == $past(req_i)));

endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
// Level-sensitive interrupt router: 9 sources onto 3 request lines
module irq_router #(
    parameter int unsigned        NUM_SRC     = 9,
    parameter int unsigned        NUM_LINE    = 3,
    parameter int unsigned        DATA_W      = 32,
    parameter int unsigned        ADDR_W      = 8,
    parameter int unsigned        PEND_LSB    = 16,
    parameter int unsigned        SYNC_STAGES = 2,
    parameter logic [NUM_SRC-1:0] FIX_MASK    = 9'h106,
    parameter logic [NUM_SRC-1:0] FIX_VAL     = 9'h102
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [NUM_LINE-1:0] irq_o
);

    import irq_router_pkg::*;

    localparam int unsigned        WORD_LSB = $clog2(DATA_W / 8);
    localparam int unsigned        IDX_W    = ADDR_W - WORD_LSB;
    localparam int unsigned        PEND_MSB = PEND_LSB + NUM_SRC - 1;
    // Synchronisers reset to the idle level of the reset polarity
    localparam logic [NUM_SRC-1:0] SYNC_RST = ~(FIX_VAL & FIX_MASK);

    logic [NUM_SRC-1:0]  level;
    logic [NUM_SRC-1:0]  pol;
    logic [NUM_SRC-1:0]  req;
    logic [IDX_W-1:0]    idx;
    logic                aligned;
    sel_e                sel_kind;
    logic [NUM_LINE-1:0] line_hit;
    logic [NUM_SRC-1:0]  line_en   [NUM_LINE];
    logic [NUM_SRC-1:0]  line_pend [NUM_LINE];
    logic                wdata_unused;

    assign wdata_unused = ^{wdata_i[PEND_LSB-1:NUM_SRC], wdata_i[DATA_W-1:PEND_MSB+1]};

    irq_sync #(
        .WIDTH   (NUM_SRC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (src_i),
        .q_o    (level)
    );

    // Address decode
    always_comb begin
        idx      = addr_i[ADDR_W-1:WORD_LSB];
        aligned  = (addr_i[WORD_LSB-1:0] == '0);
        sel_kind = SEL_NONE;
        line_hit = '0;
        if (aligned) begin
            if (idx == '0) sel_kind = SEL_POL;
            for (int l = 0; l < NUM_LINE; l++) begin
                if (idx == IDX_W'(l + 1)) begin
                    sel_kind    = SEL_LINE;
                    line_hit[l] = 1'b1;
                end
            end
        end
    end

    irq_polarity #(
        .NUM_SRC  (NUM_SRC),
        .FIX_MASK (FIX_MASK),
        .FIX_VAL  (FIX_VAL)
    ) u_pol (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_en_i && (sel_kind == SEL_POL)),
        .wdata_i (wdata_i[NUM_SRC-1:0]),
        .level_i (level),
        .pol_o   (pol),
        .req_o   (req)
    );

    for (genvar g = 0; g < NUM_LINE; g++) begin : g_line
        irq_line #(
            .NUM_SRC (NUM_SRC)
        ) u_line (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .wr_i        (wr_en_i && line_hit[g]),
            .en_wdata_i  (wdata_i[NUM_SRC-1:0]),
            .ack_wdata_i (wdata_i[PEND_MSB:PEND_LSB]),
            .req_i       (req),
            .en_o        (line_en[g]),
            .pend_o      (line_pend[g]),
            .irq_o       (irq_o[g])
        );
    end

    // Read multiplexer; unused fields stay zero
    always_comb begin
        rdata_o = '0;
        unique case (sel_kind)
            SEL_POL: begin
                rdata_o[NUM_SRC-1:0] = pol;
            end
            SEL_LINE: begin
                for (int l = 0; l < NUM_LINE; l++) begin
                    if (line_hit[l]) begin
                        rdata_o[NUM_SRC-1:0]       = line_en[l];
                        rdata_o[PEND_MSB:PEND_LSB] = line_pend[l];
                    end
                end
            end
            SEL_NONE: rdata_o = '0;
            default:  rdata_o = '0;
        endcase
    end

    // R10: at most one line register is selected per address
    a_r10_one_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(line_hit));

    // R10: unaligned addresses never select a register
    a_r10_unaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i[WORD_LSB-1:0] != '0) |-> (rdata_o == '0));

endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [8:0] IDLE_IN = 9'b011111101;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  src;
    logic [7:0]  addr;
    logic        wr_en;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_router u_irq_router (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .src_i   (src),
        .addr_i  (addr),
        .wr_en_i (wr_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // Monitor: compare one queued expectation per falling edge
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] got;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            got = it.is_irq ? {29'b0, irq} : rdata;
            n_checks++;
            if (got !== it.exp) begin
                n_err++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        addr  = a;
        wr_en = 1'b0;
        sb_q.push_back('{1'b0, e, tag});
        tick();
    endtask

    task automatic chk_irq(input logic [2:0] e, input string tag);
        sb_q.push_back('{1'b1, {29'b0, e}, tag});
        tick();
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog R1-related run hung: got timeout expected finish");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        src   = IDLE_IN;
        addr  = '0;
        wr_en = 1'b0;
        wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk_read(8'h00, 32'h0000_0102, "R1 polarity after reset");
        chk_read(8'h04, 32'h0, "R1 line0 after reset");
        chk_read(8'h08, 32'h0, "R1 line1 after reset");
        chk_read(8'h0C, 32'h0, "R1 line2 after reset");
        chk_irq(3'b000, "R1 outputs low after reset");

        // R3 R4 R10: all-ones polarity write
        bus_write(8'h00, 32'hFFFF_FFFF);
        chk_read(8'h00, 32'h0000_01FB, "R4 fixed bits and R10 upper zero");
        chk_read(8'h04, 32'h00F9_0000, "R3 active-high sources pend, R6 without enable");
        chk_irq(3'b000, "R9 masked line stays low");
        bus_write(8'h00, 32'h0);
        chk_read(8'h00, 32'h0000_0102, "R4 fixed bits survive a zero write");

        // R7 ack on one line only
        bus_write(8'h08, 32'h01FF_0000);
        chk_read(8'h08, 32'h0, "R7 line1 acked");
        chk_read(8'h04, 32'h00F9_0000, "R7 line0 untouched by line1 ack");
        bus_write(8'h04, 32'h01FF_0000);
        bus_write(8'h0C, 32'h01FF_0000);
        chk_read(8'h04, 32'h0, "R7 line0 acked");
        chk_read(8'h0C, 32'h0, "R7 line2 acked");

        // R5 enable, R2 latency
        bus_write(8'h04, 32'h0000_0020);
        src[5] = 1'b0;
        chk_read(8'h04, 32'h0000_0020, "R2 not pending before edge 1");
        chk_read(8'h04, 32'h0000_0020, "R2 not pending before edge 2");
        chk_read(8'h04, 32'h0000_0020, "R2 not pending before edge 3");
        chk_read(8'h04, 32'h0020_0020, "R2 pending after edge 3, R5 enable");
        chk_irq(3'b001, "R9 line0 raised");
        bus_write(8'h08, 32'h0000_0020);
        chk_irq(3'b011, "R9 line1 raised by enable");

        // R8 re-arm while active
        bus_write(8'h04, 32'h0020_0020);
        chk_read(8'h04, 32'h0000_0020, "R8 clear in cycle after ack");
        chk_read(8'h04, 32'h0020_0020, "R8 set again next cycle");

        // R6 sticky and R7 zero write
        src[5] = 1'b1;
        repeat (3) tick();
        bus_write(8'h04, 32'h0000_0020);
        chk_read(8'h04, 32'h0020_0020, "R7 zero write keeps flag, R6 sticky");
        bus_write(8'h04, 32'h0020_0020);
        chk_read(8'h04, 32'h0000_0020, "R7 ack of idle source");
        chk_read(8'h04, 32'h0000_0020, "R8 no re-arm when idle");

        // R4 fixed polarity in use, R6 several flags
        src[1] = 1'b1;
        src[8] = 1'b1;
        src[2] = 1'b0;
        repeat (3) tick();
        chk_read(8'h0C, 32'h0126_0000, "R6 several flags at once, R4 fixed polarity");

        // R10 unused bits
        bus_write(8'h0C, 32'hFFFF_FFFF);
        chk_read(8'h0C, 32'h0000_01FF, "R10 unused bits zero after all-ones write");
        chk_read(8'h0C, 32'h0106_01FF, "R8 live sources re-arm line2");

        // R10 unmapped
        chk_read(8'h10, 32'h0, "R10 unmapped read zero");
        chk_read(8'h02, 32'h0, "R10 unaligned read zero");
        bus_write(8'h10, 32'hFFFF_FFFF);
        chk_read(8'h00, 32'h0000_0102, "R10 unmapped write leaves polarity");
        chk_read(8'h04, 32'h0106_0020, "R10 unmapped write leaves line0");
        chk_irq(3'b110, "R9 outputs follow enable and pending");

        tick();
        tick();
        done = 1'b1;
        report();
        $finish;
    end

endmodule